// File: doc/BRIEF.md
# Bus-Master Address Phase Generator with High-Base Dual Addressing

This block drives the address phase of memory cycles that a bus master starts on a 32-bit multiplexed address/data bus. A requester gives a 32-bit low address and a read/write flag. The block puts the address on the AD lines, puts the command on the active-low CBE lines and pulls the active-low frame strobe. When the address phase is over, it pulses a done signal so that separate data-phase logic can take over. The frame strobe stays asserted until that logic reports the end of the cycle.

A 32-bit high-base register sets the addressing width, and nothing else does. When the register is zero, each cycle has one address clock. When it is nonzero, each cycle is a dual address cycle of two clocks. The first clock carries the low address with the dual-address command. The second clock carries the register value as the upper 32 address bits, with the real read/write command. The requester never supplies upper address bits. The register value is captured when a request is accepted, so a write to the register only affects later cycles. A small target-side filter reports which address phases seen on the bus this block may claim. It claims single-address memory reads and writes, and never a dual-address command.

The sequencer has five states:
- ST_IDLE: ready for a request.
- ST_ADDR_LO: first or only address clock.
- ST_ADDR_HI: second clock of a dual cycle.
- ST_DONE: one clock, with the done pulse.
- ST_DATA: frame held until the end of the cycle.

Its transitions are:
- IDLE→ADDR_LO when a request is accepted.
- ADDR_LO→DONE when the captured base is zero.
- ADDR_LO→ADDR_HI when the captured base is nonzero.
- ADDR_HI→DONE.
- DONE→IDLE when the cycle ends in that clock.
- DONE→DATA when it does not.
- DATA→IDLE when the cycle ends.

Top module: `dac_master_addr`

## Requirements
- R1: After reset: frame_n=1, cbe_n=4'hF, ad_oe=0, addr_done=0, req_ready=1, tgt_hit=0, and the base register reads as zero, which selects single addressing.
- R2: With a captured base of zero, the clock after acceptance is the only address clock. In it, ad_o equals the request address and ad_oe=1. The next clock has ad_oe=0 and addr_done=1.
- R3: Command codes are memory read 4'b0110 (req_write=0), memory write 4'b0111 (req_write=1) and dual address 4'b1101. They are driven inverted on cbe_n, and cbe_n is 4'hF outside address clocks.
- R4: With a nonzero captured base, there are two address clocks. The first has ad_o equal to the low address and cbe_n=~4'b1101. The second has ad_o equal to the base and cbe_n equal to the inverted read/write code. addr_done follows in the next clock.
- R5: addr_done is high for exactly one clock, the clock after the last address clock. frame_n is low from the first address clock until the clock after one in which cyc_end is high while in ST_DONE or ST_DATA.
- R6: The base is captured on the accepting edge, and the capture uses the register value before any write on that same edge. A write during a cycle changes neither that cycle's upper address nor its length.
- R7: Writing zero to the base register returns the next cycle to a single address clock.
- R8: req_ready is high only in ST_IDLE. req_valid is ignored while req_ready is low: no extra address phase is started and the current one is unchanged.
- R9: tgt_hit is high in the clock after a clock with tgt_start=1, if and only if tgt_cbe_n was ~4'b0110 or ~4'b0111 in that clock. A dual-address command is never claimed.
- R10: ad_oe is high exactly in address clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_wr_en | input | 1 | Write strobe for the high-base register |
| base_wr_data | input | 32 | New high-base value |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Low 32 address bits of the request |
| req_write | input | 1 | 1 = memory write, 0 = memory read |
| req_ready | output | 1 | Request accepted on this edge when valid |
| cyc_end | input | 1 | Data-phase logic ends the cycle |
| ad_o | output | 32 | AD lines value |
| ad_oe | output | 1 | AD output enable |
| cbe_n | output | 4 | Active-low command/byte-enable lines |
| frame_n | output | 1 | Active-low frame strobe |
| addr_done | output | 1 | Address phase complete, data phase may start |
| tgt_start | input | 1 | First address clock of a cycle observed on the bus |
| tgt_cbe_n | input | 4 | CBE lines observed on the bus |
| tgt_hit | output | 1 | Observed cycle may be claimed |

## Verification
The bench builds the block with the default 32-bit address width and a 4-bit command width. At these widths the all-ones base and the all-ones low address can be reached, so both halves of the 64-bit address are checked at their extremes. The base 32'h0000_0001 is also used, because it is the smallest value that must still select dual addressing.

// File: rtl/dac_pkg.sv
package dac_pkg;
    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
    localparam logic [3:0] CMD_DUAL   = 4'b1101;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR_LO = 3'd1,
        ST_ADDR_HI = 3'd2,
        ST_DONE    = 3'd3,
        ST_DATA    = 3'd4
    } phase_t;
endpackage

// File: rtl/dac_base_reg.sv
module dac_base_reg #(
    parameter int AD_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AD_W-1:0] wr_data,
    output logic [AD_W-1:0] base_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            base_o <= '0;
        else if (wr_en)
            base_o <= wr_data;
    end
endmodule

// File: rtl/dac_cmd_map.sv
module dac_cmd_map #(
    parameter int CBE_W = 4
) (
    input  logic             is_write,
    output logic [CBE_W-1:0] cmd_o
);
    import dac_pkg::*;
    always_comb begin
        cmd_o = is_write ? CMD_MEM_WR : CMD_MEM_RD;
    end
endmodule

// File: rtl/dac_addr_fsm.sv
module dac_addr_fsm #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AD_W-1:0]  req_addr,
    input  logic [CBE_W-1:0] req_cmd,
    input  logic [AD_W-1:0]  base_i,
    input  logic             cyc_end,
    output logic             req_ready,
    output logic [AD_W-1:0]  ad_o,
    output logic             ad_oe,
    output logic [CBE_W-1:0] cbe_n,
    output logic             frame_n,
    output logic             addr_done
);
    import dac_pkg::*;

    localparam logic [CBE_W-1:0] IDLE_CBE = {CBE_W{1'b1}};

    phase_t           state_q, state_d;
    logic [AD_W-1:0]  lo_q, hi_q;
    logic [CBE_W-1:0] cmd_q;
    logic             dual_q;
    logic             take;

    assign take = (state_q == ST_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // request capture, base snapshot on the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            cmd_q  <= IDLE_CBE;
            dual_q <= 1'b0;
        end else if (take) begin
            lo_q   <= req_addr;
            hi_q   <= base_i;
            cmd_q  <= req_cmd;
            dual_q <= |base_i;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_ADDR_LO;
            ST_ADDR_LO: state_d = dual_q ? ST_ADDR_HI : ST_DONE;
            ST_ADDR_HI: state_d = ST_DONE;
            ST_DONE:    state_d = cyc_end ? ST_IDLE : ST_DATA;
            ST_DATA:    if (cyc_end) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        ad_o      = '0;
        ad_oe     = 1'b0;
        cbe_n     = IDLE_CBE;
        frame_n   = 1'b0;
        addr_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                frame_n   = 1'b1;
            end
            ST_ADDR_LO: begin
                ad_o  = lo_q;
                ad_oe = 1'b1;
                cbe_n = dual_q ? ~CMD_DUAL : ~cmd_q;
            end
            ST_ADDR_HI: begin
                ad_o  = hi_q;
                ad_oe = 1'b1;
                cbe_n = ~cmd_q;
            end
            ST_DONE: addr_done = 1'b1;
            ST_DATA: ;
            default: frame_n = 1'b1;
        endcase
    end

    // R2
    single_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_LO && !dual_q) |=> (state_q == ST_DONE));
    // R4
    dual_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_LO && dual_q) |=> (state_q == ST_ADDR_HI));
    // R4
    hi_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_HI) |-> (cbe_n != ~CMD_DUAL));
    // R6
    snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_HI) |-> (hi_q == $past(hi_q)));
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |=> !addr_done);
    // R5
    done_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |-> !frame_n);
    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && state_q != ST_ADDR_LO) |=> (state_q != ST_ADDR_LO));
endmodule

// File: rtl/dac_tgt_filter.sv
module dac_tgt_filter #(
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tgt_start,
    input  logic [CBE_W-1:0] tgt_cbe_n,
    output logic             tgt_hit
);
    import dac_pkg::*;

    logic [CBE_W-1:0] seen;
    assign seen = ~tgt_cbe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tgt_hit <= 1'b0;
        else
            tgt_hit <= tgt_start && ((seen == CMD_MEM_RD) || (seen == CMD_MEM_WR));
    end

    // R9
    no_dual_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_hit |-> ($past(tgt_start) && ($past(tgt_cbe_n) != ~CMD_DUAL)));
endmodule

// File: rtl/dac_master_addr.sv
module dac_master_addr #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_wr_en,
    input  logic [AD_W-1:0]  base_wr_data,
    input  logic             req_valid,
    input  logic [AD_W-1:0]  req_addr,
    input  logic             req_write,
    output logic             req_ready,
    input  logic             cyc_end,
    output logic [AD_W-1:0]  ad_o,
    output logic             ad_oe,
    output logic [CBE_W-1:0] cbe_n,
    output logic             frame_n,
    output logic             addr_done,
    input  logic             tgt_start,
    input  logic [CBE_W-1:0] tgt_cbe_n,
    output logic             tgt_hit
);
    logic [AD_W-1:0]  base_q;
    logic [CBE_W-1:0] req_cmd;

    dac_base_reg #(.AD_W(AD_W)) u_base (
        .clk(clk), .rst_n(rst_n), .wr_en(base_wr_en),
        .wr_data(base_wr_data), .base_o(base_q)
    );

    dac_cmd_map #(.CBE_W(CBE_W)) u_cmd (
        .is_write(req_write), .cmd_o(req_cmd)
    );

    dac_addr_fsm #(.AD_W(AD_W), .CBE_W(CBE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_cmd(req_cmd), .base_i(base_q), .cyc_end(cyc_end),
        .req_ready(req_ready), .ad_o(ad_o), .ad_oe(ad_oe), .cbe_n(cbe_n),
        .frame_n(frame_n), .addr_done(addr_done)
    );

    dac_tgt_filter #(.CBE_W(CBE_W)) u_tgt (
        .clk(clk), .rst_n(rst_n), .tgt_start(tgt_start),
        .tgt_cbe_n(tgt_cbe_n), .tgt_hit(tgt_hit)
    );

    // R10
    oe_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> !frame_n);
    // R3
    idle_cbe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_oe |-> (cbe_n == {CBE_W{1'b1}}));
endmodule

// File: tb/tb_dac_master_addr.sv
module tb_dac_master_addr;
    localparam logic [3:0] RD = 4'b0110, WR = 4'b0111, DU = 4'b1101;

    logic        clk = 0, rst_n = 0;
    logic        base_wr_en = 0, req_valid = 0, req_write = 0, cyc_end = 0, tgt_start = 0;
    logic [31:0] base_wr_data = 0, req_addr = 0;
    logic [3:0]  tgt_cbe_n = 4'hF;
    logic        req_ready, ad_oe, frame_n, addr_done, tgt_hit;
    logic [31:0] ad_o;
    logic [3:0]  cbe_n;
    int          n_run = 0, n_fail = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    dac_master_addr dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_base(input logic [31:0] v);
        @(negedge clk); base_wr_en = 1; base_wr_data = v;
        @(negedge clk); base_wr_en = 0;
    endtask

    // base, addr, write
    localparam logic [64:0] VEC [7] = '{
        {32'h0000_0000, 32'h1000_0040, 1'b0},
        {32'h0000_0000, 32'hFFFF_FFFC, 1'b1},
        {32'h0000_0001, 32'h0000_0000, 1'b1},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0},
        {32'h8000_0000, 32'h2345_6780, 1'b1},
        {32'h0000_0000, 32'h0000_0800, 1'b1},
        {32'h0000_0000, 32'hABCD_0000, 1'b0}
    };

    task automatic run_vec(input logic [31:0] b, input logic [31:0] a, input logic w);
        logic [3:0] c;
        c = w ? WR : RD;
        set_base(b);
        req_valid = 1; req_addr = a; req_write = w;
        @(negedge clk); req_valid = 0;
        chk("R2 addr lo", ad_o, a);
        chk("R10 oe lo", {31'd0, ad_oe}, 1);
        chk("R5 frame lo", {31'd0, frame_n}, 0);
        chk("R8 ready busy", {31'd0, req_ready}, 0);
        if (b != 0) begin
            chk("R4 dual cmd", {28'd0, cbe_n}, {28'd0, ~DU});
            chk("R5 no done lo", {31'd0, addr_done}, 0);
            @(negedge clk);
            chk("R4 addr hi", ad_o, b);
            chk("R4 cmd hi", {28'd0, cbe_n}, {28'd0, ~c});
            chk("R10 oe hi", {31'd0, ad_oe}, 1);
        end else begin
            chk("R3 R7 cmd single", {28'd0, cbe_n}, {28'd0, ~c});
        end
        @(negedge clk);
        chk("R5 done", {31'd0, addr_done}, 1);
        chk("R10 oe off", {31'd0, ad_oe}, 0);
        chk("R3 cbe idle", {28'd0, cbe_n}, 32'hF);
        chk("R5 frame done", {31'd0, frame_n}, 0);
        cyc_end = 1;
        @(negedge clk); cyc_end = 0;
        chk("R5 frame end", {31'd0, frame_n}, 1);
        chk("R5 done gone", {31'd0, addr_done}, 0);
        chk("R8 ready idle", {31'd0, req_ready}, 1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 frame", {31'd0, frame_n}, 1);
        chk("R1 cbe", {28'd0, cbe_n}, 32'hF);
        chk("R1 oe", {31'd0, ad_oe}, 0);
        chk("R1 done", {31'd0, addr_done}, 0);
        chk("R1 ready", {31'd0, req_ready}, 1);
        chk("R1 hit", {31'd0, tgt_hit}, 0);
        rst_n = 1;
        // R1: base reads as zero, so the first request is single
        @(negedge clk); req_valid = 1; req_addr = 32'h55; req_write = 0;
        @(negedge clk); req_valid = 0;
        chk("R1 single after reset", {28'd0, cbe_n}, {28'd0, ~RD});
        @(negedge clk);
        chk("R1 done after one", {31'd0, addr_done}, 1);
        cyc_end = 1; @(negedge clk); cyc_end = 0;

        for (int i = 0; i < 7; i++)
            run_vec(VEC[i][64:33], VEC[i][32:1], VEC[i][0]);

        // R6: a write in the accepting edge and during the cycle does not alter it
        set_base(32'h0000_00AA);
        base_wr_en = 1; base_wr_data = 32'h0000_00BB;
        req_valid = 1; req_addr = 32'h10; req_write = 1;
        @(negedge clk);
        base_wr_data = 32'h0000_0000; req_valid = 1; req_addr = 32'h99;
        chk("R6 dual kept", {28'd0, cbe_n}, {28'd0, ~DU});
        chk("R8 addr unchanged", ad_o, 32'h10);
        @(negedge clk); base_wr_en = 0;
        chk("R6 old base used", ad_o, 32'hAA);
        chk("R8 no restart", {31'd0, ad_oe}, 1);
        @(negedge clk); req_valid = 0;
        chk("R6 done", {31'd0, addr_done}, 1);
        // R5: frame held while cyc_end low
        repeat (3) @(negedge clk);
        chk("R5 frame held", {31'd0, frame_n}, 0);
        chk("R5 done single pulse", {31'd0, addr_done}, 0);
        chk("R8 no extra phase", {31'd0, ad_oe}, 0);
        cyc_end = 1; @(negedge clk); cyc_end = 0;
        chk("R5 release", {31'd0, frame_n}, 1);
        // R7: base now zero from the in-cycle write
        req_valid = 1; req_addr = 32'h20; req_write = 0;
        @(negedge clk); req_valid = 0;
        chk("R7 single", {28'd0, cbe_n}, {28'd0, ~RD});
        @(negedge clk);
        chk("R7 done", {31'd0, addr_done}, 1);
        cyc_end = 1; @(negedge clk); cyc_end = 0;

        // R9 target filter
        tgt_start = 1; tgt_cbe_n = ~RD; @(negedge clk);
        chk("R9 claim rd", {31'd0, tgt_hit}, 1);
        tgt_cbe_n = ~DU; @(negedge clk);
        chk("R9 no dual", {31'd0, tgt_hit}, 0);
        tgt_cbe_n = ~WR; @(negedge clk);
        chk("R9 claim wr", {31'd0, tgt_hit}, 1);
        tgt_cbe_n = ~4'b0010; @(negedge clk);
        chk("R9 other cmd", {31'd0, tgt_hit}, 0);
        tgt_start = 0; tgt_cbe_n = ~RD; @(negedge clk);
        chk("R9 no start", {31'd0, tgt_hit}, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule